// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Result Strobe

The scanner takes a five-digit BCD result from the conversion sequencer and places it on a shared 4-bit data bus, one digit at a time. A positive select line marks which digit is on the bus. The slots run in order from the most significant digit to the least significant one and then start again. This lets a multiplexed display be refreshed continuously.

When the sequencer signals that a new result has been latched, the scan restarts at the most significant digit. An active-low strobe then marks the centre of each of the next five digit slots, once per digit, so external latches or a serial transmitter can capture the value. The strobe is half a clock long and occupies the low phase of the centre clock.

The sequencer also supplies an overrange flag. While that flag is high, the data bus reads zero. If the flag is high when the fifth strobe fires, every select line stays low until the sequencer signals the start of its next reference-integrate phase. The display therefore blinks.

Top module: `digit_scanner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all of `digitSel` is 0 and `strobeN` is 1.
- R2: Exactly one select is high at a time, in the repeating order bit 4, 3, 2, 1, 0 of `digitSel`. Bit 4 is the most significant digit and bit 0 the least significant.
- R3: The slot of the most significant digit lasts 201 clocks. Every other slot lasts 200 clocks.
- R4: `bcdOut` carries the digit whose select is high. `digitsIn[19:16]` is the most significant digit (bit 4) and `digitsIn[3:0]` the least significant (bit 0).
- R5: A `measDone` pulse sampled at a clock edge starts a most-significant slot in the cycle that follows, whatever the scan position was.
- R6: After `measDone`, `strobeN` goes low once in each of the next five slots. In the first slot this happens in the cycle at offset 101 from the slot's first cycle. In the later slots it happens at offset 100.
- R7: `strobeN` is low only during the low phase of that centre cycle, which is half a clock period, and is high during the high phase.
- R8: After the fifth strobe, no further strobe appears until the next `measDone`, although scanning continues.
- R9: While `overRange` is high, `bcdOut` is 0.
- R10: If `overRange` is high in the cycle of the fifth strobe, `digitSel` is 0 from the next cycle until the cycle after a `refIntStart` pulse. The slot timing keeps running while the selects are low, so the scan resumes at its time-correct position.
- R11: A `measDone` that falls in a strobe's centre cycle still lets that strobe appear. The scan then restarts, and five fresh strobes follow.
- R12: A `refIntStart` in the same cycle as an overranged fifth strobe wins, and no blanking occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its low phase shapes the strobe |
| rst | input | 1 | Synchronous reset, active high |
| digitsIn | input | 20 | Latched result, five BCD digits, most significant in [19:16] |
| overRange | input | 1 | Overrange flag from the sequencer |
| measDone | input | 1 | One-cycle pulse: a new result has been latched |
| refIntStart | input | 1 | One-cycle pulse: reference-integrate phase begins |
| digitSel | output | 5 | One-hot digit select, bit 4 = most significant digit |
| bcdOut | output | 4 | BCD value of the selected digit |
| strobeN | output | 1 | Active-low half-clock capture strobe |

## Verification
Two events can land in the same cycle. A new-result pulse can arrive in the very cycle that a strobe is being emitted, and the end of the blanking window can coincide with the overranged fifth strobe that would start it. Both cases are provoked on purpose by counting cycles from a restart and pulsing the input exactly in the centre cycle of a slot. The first case is judged by counting the strobes seen at the pin: seven are expected, two from the old result and five from the new one. The second case is judged by the selects staying live in the cycle after the coincidence. Both are also compared cycle by cycle against a bench model built from the slot-length rules.

// File: rtl/digit_scanner_pkg.sv
package digit_scanner_pkg;
  localparam int NUM_DIGITS = 5;
  localparam int BCD_W      = 4;
  localparam int SLOT_W     = $clog2(NUM_DIGITS);
  localparam int LEFT_W     = $clog2(NUM_DIGITS + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic              active;  // scanning enabled (not in reset cycle)
    logic              blank;   // overrange blink window
    logic              centre;  // strobe cycle
    logic [SLOT_W-1:0] slot;    // 0 = most significant digit
  } scanCtl_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import digit_scanner_pkg::*;
#(
  parameter int FIRST_LEN = 201,
  parameter int REST_LEN  = 200,
  parameter int FIRST_CTR = 101,
  parameter int REST_CTR  = 100
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     overRange,
  input  logic     measDone,
  input  logic     refIntStart,
  output scanCtl_t ctl
);
  localparam int MAX_LEN = (FIRST_LEN > REST_LEN) ? FIRST_LEN : REST_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0]  FIRST_END = CNT_W'(FIRST_LEN - 1);
  localparam logic [CNT_W-1:0]  REST_END  = CNT_W'(REST_LEN - 1);
  localparam logic [CNT_W-1:0]  FIRST_MID = CNT_W'(FIRST_CTR);
  localparam logic [CNT_W-1:0]  REST_MID  = CNT_W'(REST_CTR);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_DIGITS - 1);
  localparam logic [LEFT_W-1:0] ALL_LEFT  = LEFT_W'(NUM_DIGITS);

  logic              active;
  logic              blank;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  cnt;
  logic [LEFT_W-1:0] left;
  logic [CNT_W-1:0]  slotEnd;
  logic [CNT_W-1:0]  slotMid;
  logic              centre;
  logic              lastStrobe;

  always_comb begin
    slotEnd    = (slot == '0) ? FIRST_END : REST_END;
    slotMid    = (slot == '0) ? FIRST_MID : REST_MID;
    centre     = active && (left != '0) && (cnt == slotMid);
    lastStrobe = centre && (left == LEFT_W'(1));
  end

  // slot position and pending strobe count
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      slot   <= '0;
      cnt    <= '0;
      left   <= '0;
    end else begin
      active <= 1'b1;
      if (measDone) begin
        slot <= '0;
        cnt  <= '0;
        left <= ALL_LEFT;
      end else if (active) begin
        if (cnt == slotEnd) begin
          cnt  <= '0;
          slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (centre) left <= left - 1'b1;
      end
    end
  end

  // overrange blink window; release has priority over start
  always_ff @(posedge clk) begin
    if (rst)                                     blank <= 1'b0;
    else if (refIntStart)                        blank <= 1'b0;
    else if (lastStrobe && overRange && !measDone) blank <= 1'b1;
  end

  assign ctl = '{active: active, blank: blank, centre: centre, slot: slot};

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    measDone |=> (slot == '0 && cnt == '0));
  p_single_centre_r6: assert property (@(posedge clk) disable iff (rst)
    centre |=> !centre);
  p_no_extra_r8: assert property (@(posedge clk) disable iff (rst)
    (left == '0 && !measDone) |=> (left == '0));
  p_blank_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (blank && !refIntStart) |=> blank);
  p_blank_release_r12: assert property (@(posedge clk) disable iff (rst)
    refIntStart |=> !blank);
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import digit_scanner_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  scanCtl_t                    ctl,
  input  logic [NUM_DIGITS*BCD_W-1:0] digitsIn,
  input  logic                        overRange,
  output logic [NUM_DIGITS-1:0]       digitSel,
  output logic [BCD_W-1:0]            bcdOut,
  output logic                        strobeN
);
  // slot i drives select bit NUM_DIGITS-1-i
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
    assign digitSel[NUM_DIGITS-1-i] =
      ctl.active && !ctl.blank && (ctl.slot == SLOT_W'(i));
  end

  always_comb begin
    bcdOut = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (ctl.slot == SLOT_W'(i))
        bcdOut = digitsIn[(NUM_DIGITS-1-i)*BCD_W +: BCD_W];
    end
    if (overRange) bcdOut = '0;
  end

  // low only in the second (clock-low) half of the centre cycle
  assign strobeN = !(ctl.centre && !clk);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digitSel));
  p_live_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.active && !ctl.blank) |-> ($countones(digitSel) == 1));
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
  import digit_scanner_pkg::*;
#(
  parameter int FIRST_LEN = 201,
  parameter int REST_LEN  = 200,
  parameter int FIRST_CTR = 101,
  parameter int REST_CTR  = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [19:0] digitsIn,
  input  logic        overRange,
  input  logic        measDone,
  input  logic        refIntStart,
  output logic [4:0]  digitSel,
  output logic [3:0]  bcdOut,
  output logic        strobeN
);
  scanCtl_t ctl;

  scan_ctrl #(
    .FIRST_LEN(FIRST_LEN), .REST_LEN(REST_LEN),
    .FIRST_CTR(FIRST_CTR), .REST_CTR(REST_CTR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .overRange(overRange),
    .measDone(measDone), .refIntStart(refIntStart), .ctl(ctl)
  );

  scan_datapath u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .digitsIn(digitsIn),
    .overRange(overRange), .digitSel(digitSel), .bcdOut(bcdOut),
    .strobeN(strobeN)
  );
endmodule

// File: tb/digit_scanner_test.sv
`timescale 1ns/1ps
module digit_scanner_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] digitsIn = 20'h12345;
  logic        overRange = 1'b0;
  logic        measDone = 1'b0;
  logic        refIntStart = 1'b0;
  logic [4:0]  digitSel;
  logic [3:0]  bcdOut;
  logic        strobeN;

  always #2 clk = ~clk;  // 250 MHz

  digit_scanner uut (.*);

  int total = 0, bad = 0, obsStrobes = 0;
  bit finished = 0;
  string phaseTag = "";

  // bench model state
  bit mAct = 0, mBlank = 0;
  int mK = 0, mLeft = 0;

  localparam int FRAME = 201 + 4*200;

  function automatic int slotOf(int k);
    int kk = k % FRAME;
    return (kk < 201) ? 0 : 1 + (kk - 201) / 200;
  endfunction
  function automatic int offOf(int k);
    int kk = k % FRAME;
    return (kk < 201) ? kk : (kk - 201) % 200;
  endfunction
  function automatic bit expCentre();
    return mAct && mLeft > 0 && offOf(mK) == ((slotOf(mK) == 0) ? 101 : 100);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tagOr(string dflt);
    return (phaseTag != "") ? phaseTag : dflt;
  endfunction

  task automatic cycle();
    bit c;
    int s;
    logic [4:0] eSel;
    logic [3:0] eBcd;
    @(posedge clk);
    // model advance using state before the edge and inputs sampled at it
    c = expCentre();
    if (rst) begin
      mAct = 0; mK = 0; mLeft = 0; mBlank = 0;
    end else begin
      if (refIntStart) mBlank = 0;
      else if (c && mLeft == 1 && overRange && !measDone) mBlank = 1;
      if (measDone) begin mK = 0; mLeft = 5; end
      else if (mAct) begin
        mK = (mK + 1) % FRAME;
        if (c) mLeft--;
      end
      mAct = 1;
    end
    #1;
    s = slotOf(mK);
    eSel = (mAct && !mBlank) ? 5'(1 << (4 - s)) : 5'd0;
    eBcd = overRange ? 4'd0 : digitsIn[(4-s)*4 +: 4];
    if (!mAct) check(digitSel == 5'd0, "R1", digitSel, 0);
    else check(digitSel == eSel, tagOr(mBlank ? "R10" : "R3"), digitSel, eSel);
    if (mAct) check(bcdOut == eBcd, tagOr(overRange ? "R9" : "R4"), bcdOut, eBcd);
    check(strobeN == 1'b1, mAct ? "R7" : "R1", strobeN, 1);
    #2;
    c = expCentre();
    if (strobeN == 1'b0) obsStrobes++;
    check(strobeN == !c, tagOr(c ? "R6" : "R8"), strobeN, !c);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic pulseMeas();
    measDone = 1; cycle(); measDone = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    run(3);
    rst = 0;
    run(1100);                      // R2, R3, R4: free scan, no strobes (R8)
    digitsIn = 20'h98760;
    phaseTag = "R5"; pulseMeas(); phaseTag = "";
    run(1200);                      // R6, R7 then R8
    // R9, R10: overranged result blinks until reference integrate
    overRange = 1; pulseMeas(); run(1100);
    refIntStart = 1; cycle(); refIntStart = 0;
    run(300);
    overRange = 0;
    // R11: new result in a strobe centre cycle
    pulseMeas();
    obsStrobes = 0;
    run(301);
    phaseTag = "R11"; measDone = 1; cycle(); measDone = 0; phaseTag = "";
    run(1100);
    check(obsStrobes == 7, "R11", obsStrobes, 7);
    // R12: release coinciding with overranged fifth strobe
    overRange = 1; pulseMeas(); run(901);
    phaseTag = "R12"; refIntStart = 1; cycle(); refIntStart = 0;
    run(5);
    check(digitSel != 5'd0, "R12", digitSel, 1);
    phaseTag = "";
    run(300);
    overRange = 0;
    // randomized mix
    for (int i = 0; i < 9000; i++) begin
      if ($urandom_range(0, 49) == 0)
        for (int d = 0; d < 5; d++) digitsIn[d*4 +: 4] = 4'($urandom_range(0, 9));
      if ($urandom_range(0, 1499) == 0) overRange = ~overRange;
      measDone    = ($urandom_range(0, 2499) == 0);
      refIntStart = ($urandom_range(0, 1999) == 0);
      if ($urandom_range(0, 7999) == 0) rst = 1; else rst = 0;
      cycle();
    end
    measDone = 0; refIntStart = 0; rst = 0;
    run(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule